// File: doc/BRIEF.md
# Multi-Width Shift and Rotate Unit

This unit performs the shift and rotate instructions of a two-address, memory-to-memory processor. The processor fetches the operand from the destination address and hands the unit the 32-bit instruction word, the operand and the current carry flag. The unit decodes the operation and the operand size from the opcode and reads the shift count from the source-address field. One cycle later it returns the result, which is written back to the same address, and the new carry flag.

It supports four operand sizes: 8, 16, 32 and 64 bits. The operations are logical left and right shifts, arithmetic right shift, plain rotates in both directions, and rotates in both directions through the carry flag. Opcodes that fall outside the shift group, and the single unused slot inside it, are reported as illegal. In that case the operand and the carry pass through unchanged.

Top module: `shrot_unit`

## Requirements
- R1: The instruction word holds the opcode in bits [31:24], the shift count in bits [23:12] (unsigned, 0 to 4095) and the destination address in bits [11:0], which the unit does not use. For opcode high nibble 0xE, opcode bit 27 = 0 selects byte and bit 27 = 1 selects halfword (16 bits). For high nibble 0xF it selects word (32 bits) or long (64 bits). Opcode bits [26:24] select the operation.
- R2: Operation 0 is a logical left shift. The carry becomes the last bit shifted out of the top of the operand. A count greater than the width gives zero, with carry 0. A count equal to the width gives zero, with carry equal to the original bit 0.
- R3: Operation 1 is a logical right shift. The carry becomes the last bit shifted out of bit 0. A count at or above the width gives zero.
- R4: Operation 3 is an arithmetic right shift that fills from the sign bit of the selected width. A count at or above the width gives all copies of the sign bit, with carry equal to the sign bit.
- R5: Operation 4 rotates left and operation 5 rotates right, with the count taken modulo the width. For a nonzero count the carry equals the bit that last wrapped around: result bit 0 for a left rotate, the result's top bit for a right rotate.
- R6: Operations 6 (left) and 7 (right) rotate the width+1-bit value formed by the carry above the operand. The count is taken modulo width+1. The new carry is the top bit of the rotated value.
- R7: A count of zero returns the operand and the carry unchanged, for every operation.
- R8: Operation 2, or an opcode high nibble other than 0xE or 0xF, raises `illegal` and returns the operand masked to the decoded size with the carry unchanged. All legal opcodes clear `illegal`.
- R9: Result bits above the selected width are always zero.
- R10: `out_valid` pulses in the cycle after `in_valid`. Result, carry and `illegal` change only on an accepted strobe. Synchronous reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: instruction, operand and carry are valid |
| instr | input | 32 | Instruction word |
| operand | input | 64 | Value fetched from the destination address, right-aligned |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | One-cycle done pulse |
| result | output | 64 | Value to write back, zero above the selected width |
| carry_out | output | 1 | Updated carry flag |
| illegal | output | 1 | Opcode is not a valid shift or rotate |

## Verification
The bench checks every result against a bit-serial model that steps the operand one position per count. Because the only state is the output register stage, a wrong size or operation decode shows as a wrong result or carry in the very cycle of `out_valid`. Likewise, a wrong modulus in the rotate paths is visible on the first count that wraps past the width. Directed cases target the count boundaries: zero, width−1, width, width+1, and counts above 64. A randomized sweep then covers all sizes and operations.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int DATA_W = 64;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_LONG = 2'd3} size_e;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0, OP_SHR = 3'd1, OP_NONE = 3'd2, OP_ASR = 3'd3,
    OP_ROL = 3'd4, OP_ROR = 3'd5, OP_RCL = 3'd6, OP_RCR = 3'd7
  } shop_e;

  function automatic logic [DATA_W-1:0] size_mask(size_e s);
    logic [DATA_W-1:0] one;
    one = {{(DATA_W-1){1'b0}}, 1'b1};
    return (one << (8 << s)) - one;
  endfunction
endpackage

// File: rtl/shrot_decode.sv
module shrot_decode
  import shrot_pkg::*;
(
  input  logic [7:0] opcode,
  output size_e      size,
  output shop_e      op,
  output logic       bad
);
  always_comb begin
    size = size_e'({opcode[4], opcode[3]});
    op   = shop_e'(opcode[2:0]);
    bad  = (opcode[7:5] != 3'b111) || (opcode[2:0] == 3'd2);
  end
endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
  import shrot_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 12
) (
  input  shop_e            op,
  input  logic [CNT_W-1:0] cnt,
  input  logic [W-1:0]     a,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout
);
  localparam int KW = $clog2(W);

  logic [CNT_W-1:0]      cl_sh, cl_ar, rc_k;
  logic [KW-1:0]         rot_k;
  logic [2*W-1:0]        lsh, rsh, rotl, rotr;
  logic signed [2*W-1:0] ash;
  logic [W:0]            ring;
  logic [2*W+1:0]        rcl, rcr;

  always_comb begin
    cl_sh = (cnt > CNT_W'(W + 1)) ? CNT_W'(W + 1) : cnt;
    cl_ar = (cnt > CNT_W'(W)) ? CNT_W'(W) : cnt;
    rot_k = cnt[KW-1:0];
    rc_k  = CNT_W'(cnt % CNT_W'(W + 1));
    ring  = {cin, a};
    lsh   = {{W{1'b0}}, a} << cl_sh;
    rsh   = {a, {W{1'b0}}} >> cl_sh;
    ash   = $signed({a, {W{1'b0}}}) >>> cl_ar;
    rotl  = {a, a} << rot_k;
    rotr  = {a, a} >> rot_k;
    rcl   = {ring, ring} << rc_k;
    rcr   = {ring, ring} >> rc_k;
    res   = a;
    cout  = cin;
    unique case (op)
      OP_SHL:  begin res = lsh[W-1:0];       cout = lsh[W];           end
      OP_SHR:  begin res = rsh[2*W-1:W];     cout = rsh[W-1];         end
      OP_ASR:  begin res = ash[2*W-1:W];     cout = ash[W-1];         end
      OP_ROL:  begin res = rotl[2*W-1:W];    cout = rotl[W];          end
      OP_ROR:  begin res = rotr[W-1:0];      cout = rotr[W-1];        end
      OP_RCL:  begin res = rcl[2*W:W+1];     cout = rcl[2*W+1];       end
      OP_RCR:  begin res = rcr[W-1:0];       cout = rcr[W];           end
      default: begin res = a;                cout = cin;              end
    endcase
    if (cnt == '0) begin
      res  = a;
      cout = cin;
    end
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int CNT_W   = 12,
  parameter int BASE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [63:0]        operand,
  input  logic               carry_in,
  output logic               out_valid,
  output logic [63:0]        result,
  output logic               carry_out,
  output logic               illegal
);
  localparam int N_SIZES = 4;
  localparam int OPC_LSB = INSTR_W - 8;
  localparam int CNT_LSB = OPC_LSB - CNT_W;

  size_e             dec_size, q_size;
  shop_e             dec_op;
  logic              dec_bad;
  logic [CNT_W-1:0]  cnt;
  logic [63:0]       lane_res [N_SIZES];
  logic              lane_c   [N_SIZES];
  logic [63:0]       nxt_res;
  logic              nxt_c;

  assign cnt = instr[CNT_LSB +: CNT_W];

  shrot_decode u_dec (
    .opcode (instr[INSTR_W-1 -: 8]),
    .size   (dec_size),
    .op     (dec_op),
    .bad    (dec_bad)
  );

  for (genvar g = 0; g < N_SIZES; g++) begin : g_lane
    localparam int LW = BASE_W << g;
    logic [LW-1:0] r;
    logic          c;
    shrot_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
      .op   (dec_op),
      .cnt  (cnt),
      .a    (operand[LW-1:0]),
      .cin  (carry_in),
      .res  (r),
      .cout (c)
    );
    assign lane_res[g] = 64'(r);
    assign lane_c[g]   = c;
  end

  always_comb begin
    nxt_res = lane_res[dec_size];
    nxt_c   = lane_c[dec_size];
    if (dec_bad) begin
      nxt_res = operand & size_mask(dec_size);
      nxt_c   = carry_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
      illegal   <= 1'b0;
      q_size    <= SZ_BYTE;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_res;
        carry_out <= nxt_c;
        illegal   <= dec_bad;
        q_size    <= dec_size;
      end
    end
  end

  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && $stable(carry_out) && !out_valid); // R10
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (result & ~size_mask(q_size)) == '0); // R9
  AST_ZERO_COUNT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    in_valid && cnt == '0 |=> result == $past(operand & size_mask(dec_size))
                              && carry_out == $past(carry_in)); // R7
  AST_ILLEGAL_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    in_valid && dec_bad |=> illegal && carry_out == $past(carry_in)); // R8
endmodule

// File: tb/shrot_unit_test.sv
module shrot_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] operand = '0;
  logic        carry_in = 1'b0;
  logic        out_valid, carry_out, illegal;
  logic [63:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  shrot_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .operand(operand), .carry_in(carry_in), .out_valid(out_valid),
    .result(result), .carry_out(carry_out), .illegal(illegal)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bit-serial model: one position per count step.
  task automatic model(input logic [7:0] opc, input logic [11:0] n, input logic [63:0] v,
                       input logic c, output logic [63:0] r, output logic co, output logic bad);
    int w;
    logic [63:0] m, a;
    logic cc, t;
    w  = 8 << {opc[4], opc[3]};
    m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    a  = v & m;
    cc = c;
    bad = (opc[7:4] != 4'hE && opc[7:4] != 4'hF) || opc[2:0] == 3'd2;
    if (!bad) begin
      for (int i = 0; i < int'(n); i++) begin
        case (opc[2:0])
          3'd0: begin cc = a[w-1]; a = (a << 1) & m; end
          3'd1: begin cc = a[0]; a = a >> 1; end
          3'd3: begin cc = a[0]; a = (a >> 1) | ({63'd0, a[w-1]} << (w-1)); end
          3'd4: begin cc = a[w-1]; a = ((a << 1) | {63'd0, cc}) & m; end
          3'd5: begin cc = a[0]; a = (a >> 1) | ({63'd0, cc} << (w-1)); end
          3'd6: begin t = a[w-1]; a = ((a << 1) | {63'd0, cc}) & m; cc = t; end
          default: begin t = a[0]; a = (a >> 1) | ({63'd0, cc} << (w-1)); cc = t; end
        endcase
      end
    end
    r = a; co = cc;
  endtask

  task automatic run(input string tag, input logic [7:0] opc, input logic [11:0] n,
                     input logic [63:0] v, input logic c);
    logic [63:0] er; logic ec, eb;
    model(opc, n, v, c, er, ec, eb);
    @(negedge clk);
    instr = {opc, n, 12'h5A5};
    operand = v; carry_in = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " done pulse (R10)"}, {63'd0, out_valid}, 64'd1);
    check({tag, " result"}, result, er);
    check({tag, " carry"}, {63'd0, carry_out}, {63'd0, ec});
    check({tag, " illegal (R8)"}, {63'd0, illegal}, {63'd0, eb});
  endtask

  task automatic t_reset;
    check("R10 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R10 reset result", result, 64'd0);
    check("R10 reset carry", {63'd0, carry_out}, 64'd0);
  endtask

  task automatic t_shl;
    run("R2 SHL byte 3", 8'hE0, 12'd3, 64'hFFFF_FFFF_FFFF_FF96, 1'b0);
    run("R2 SHL byte =w", 8'hE0, 12'd8, 64'h0000_0000_0000_0081, 1'b0);
    run("R2 SHL half >w", 8'hE8, 12'd17, 64'h0000_0000_0000_FFFF, 1'b1);
    run("R2 SHL long 63", 8'hF8, 12'd63, 64'h0000_0000_0000_0003, 1'b0);
    run("R1 SHL word large", 8'hF0, 12'd4095, 64'h1234_5678_9ABC_DEF0, 1'b1);
  endtask

  task automatic t_shr;
    run("R3 SHR half 5", 8'hE9, 12'd5, 64'h0000_0000_0000_8030, 1'b1);
    run("R3 SHR word =w", 8'hF1, 12'd32, 64'h0000_0000_8000_0001, 1'b0);
    run("R3 SHR long 70", 8'hF9, 12'd70, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
  endtask

  task automatic t_asr;
    run("R4 ASR byte neg", 8'hE3, 12'd2, 64'h0000_0000_0000_0085, 1'b0);
    run("R4 ASR half >w", 8'hEB, 12'd40, 64'h0000_0000_0000_8000, 1'b0);
    run("R4 ASR word pos", 8'hF3, 12'd100, 64'h0000_0000_7FFF_FFFF, 1'b1);
    run("R4 ASR long neg", 8'hFB, 12'd1, 64'h8000_0000_0000_0002, 1'b1);
  endtask

  task automatic t_rot;
    run("R5 ROL byte 3", 8'hE4, 12'd3, 64'h0000_0000_0000_00A1, 1'b0);
    run("R5 ROR byte 9", 8'hE5, 12'd9, 64'h0000_0000_0000_0001, 1'b0);
    run("R5 ROL long 64", 8'hFC, 12'd64, 64'h8000_0000_0000_0001, 1'b0);
    run("R5 ROR word 33", 8'hF5, 12'd33, 64'hFFFF_FFFF_0000_0002, 1'b1);
  endtask

  task automatic t_rc;
    run("R6 RCL byte 1", 8'hE6, 12'd1, 64'h0000_0000_0000_0080, 1'b1);
    run("R6 RCL byte 9", 8'hE6, 12'd9, 64'h0000_0000_0000_005C, 1'b1);
    run("R6 RCR half 17", 8'hEF, 12'd17, 64'h0000_0000_0000_1234, 1'b0);
    run("R6 RCR long 65", 8'hFF, 12'd65, 64'hDEAD_BEEF_0123_4567, 1'b1);
    run("R6 RCL word 40", 8'hF6, 12'd40, 64'h0000_0000_C001_0003, 1'b0);
  endtask

  task automatic t_zero;
    run("R7 zero SHL carry1", 8'hE0, 12'd0, 64'h0000_0000_0000_00F1, 1'b1);
    run("R7 zero RCR long", 8'hFF, 12'd0, 64'hFEDC_BA98_7654_3210, 1'b0);
    run("R9 upper cleared half", 8'hEC, 12'd4, 64'hAAAA_BBBB_CCCC_1234, 1'b0);
  endtask

  task automatic t_illegal;
    run("R8 offset 2 word", 8'hF2, 12'd5, 64'hFFFF_FFFF_1234_5678, 1'b1);
    run("R8 nibble 0xD", 8'hD0, 12'd5, 64'h0000_0000_0000_0042, 1'b0);
    run("R8 legal after bad", 8'hE1, 12'd1, 64'h0000_0000_0000_0003, 1'b0);
  endtask

  task automatic t_hold;
    logic [63:0] keep;
    keep = result;
    @(negedge clk);
    instr = {8'hE0, 12'd1, 12'd0}; operand = '1; carry_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 no strobe no pulse", {63'd0, out_valid}, 64'd0);
    check("R10 no strobe result held", result, keep);
  endtask

  task automatic t_sweep;
    logic [7:0] opc;
    logic [11:0] n;
    for (int i = 0; i < 240; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      opc = {3'b111, lfsr[3], lfsr[4], lfsr[7:5]};
      n = lfsr[8] ? {6'd0, lfsr[45:40]} + 12'd1 : {4'd0, lfsr[47:40]};
      run("R1 sweep", opc, n, {lfsr[31:0], lfsr[63:32]} ^ lfsr, lfsr[9]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_shl();
    t_shr();
    t_asr();
    t_rot();
    t_rc();
    t_zero();
    t_illegal();
    t_hold();
    t_sweep();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule